// File: doc/BRIEF.md
# Miscellaneous Control Instruction Executor

This block carries out a small family of single-cycle control instructions for a 32-bit CPU that has a general register file. Each cycle it can take one already-fetched instruction. The instruction arrives as a primary opcode byte, a 4-bit sub-code and an 8-bit immediate, together with the source register operand and the current stack pointer (R15). The block handles five kinds of work:

- a no-operation;
- AND or OR of the immediate into the condition-code register;
- loading the interrupt level mask;
- moving the stack pointer by a signed, word-scaled offset;
- widening a byte or halfword in a register to 32 bits, signed or unsigned.

The block owns the condition-code register and the interrupt level mask. It returns a register write-back and a stack-pointer write to the register file. It raises a one-cycle flag for any encoding outside its group. Results appear on the cycle after the instruction is presented.

Top module: `misc_exec`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the CCR reads 0x00, the mask reads 0, and `wb_en_o`, `sp_we_o` and `illegal_o` are all 0.
- R2: Opcode 0x9F with sub-code 0xA is a no-operation. It asserts no write enable and no illegal flag, and leaves the CCR and the mask unchanged.
- R3: Opcode 0x83 replaces the 8-bit CCR with CCR AND imm. The CCR holds C in bit 0, V in bit 1, Z in bit 2 and N in bit 3.
- R4: Opcode 0x93 replaces the 8-bit CCR with CCR OR imm.
- R5: Opcode 0x87 loads the interrupt level mask from imm bits 4:0. Imm bits 7:5 have no effect on it.
- R6: Opcode 0xA3 writes R15 with `sp_i` + 4 × (imm read as a signed 8-bit value), wrapping modulo 2^32, and pulses `sp_we_o`.
- R7: Opcode 0x97 writes back register `ri_idx_i` with `ri_i` widened to 32 bits. Sub-code 0x8 sign-extends bits 7:0, 0x9 zero-extends bits 7:0, 0xA sign-extends bits 15:0, and 0xB zero-extends bits 15:0.
- R8: No instruction other than opcodes 0x83 and 0x93 changes the CCR.
- R9: Any other opcode, 0x9F with a sub-code other than 0xA, or 0x97 with a sub-code outside 0x8..0xB raises `illegal_o`. Such an instruction asserts no write enable and leaves the CCR and the mask unchanged.
- R10: On a cycle with `valid_i` low, no write enable and no illegal flag is asserted on the next cycle.
- R11: Every effect appears on the cycle after the instruction is presented. `wb_en_o`, `sp_we_o` and `illegal_o` are single-cycle pulses for each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 8 | Primary opcode byte |
| subop_i | input | 4 | Sub-code nibble |
| imm_i | input | 8 | 8-bit immediate |
| ri_idx_i | input | 4 | Index of the register to widen |
| ri_i | input | 32 | Read data of that register |
| sp_i | input | 32 | Current R15 value |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | 4 | Register write-back index |
| wb_data_o | output | 32 | Register write-back data |
| sp_we_o | output | 1 | R15 write enable |
| sp_data_o | output | 32 | New R15 value |
| ccr_o | output | 8 | Condition-code register |
| ilm_o | output | 5 | Interrupt level mask |
| illegal_o | output | 1 | Unsupported encoding, one-cycle pulse |

## Verification
The CCR and the mask are the only state that persists, and both are visible directly at the ports. A wrong flag bit or mask bit therefore shows on the cycle after the instruction that caused it. It then stays visible on every later comparison until another CCR or mask instruction overwrites it. A decode fault shows as a write pulse, or an illegal pulse, on the wrong instruction in that same next cycle. The reference model compares every output on every clock, so any fault surfaces within one cycle of the instruction that exposes it.

// File: rtl/misc_exec_pkg.sv
// Package: encodings and the decoded operation kind shared by the
// miscellaneous instruction executor and its sub-blocks.
// Assumes a byte-wide primary opcode and a 4-bit sub-code.
package misc_exec_pkg;

    typedef enum logic [3:0] {
        K_NOP,
        K_ANDCCR,
        K_ORCCR,
        K_STILM,
        K_ADDSP,
        K_EXTSB,
        K_EXTUB,
        K_EXTSH,
        K_EXTUH,
        K_ILLEGAL
    } op_kind_e;

    localparam logic [7:0] OPC_GRP_E  = 8'h9F;
    localparam logic [7:0] OPC_ANDCCR = 8'h83;
    localparam logic [7:0] OPC_ORCCR  = 8'h93;
    localparam logic [7:0] OPC_STILM  = 8'h87;
    localparam logic [7:0] OPC_ADDSP  = 8'hA3;
    localparam logic [7:0] OPC_EXT    = 8'h97;

    localparam logic [3:0] SUB_NOP   = 4'hA;
    localparam logic [3:0] SUB_EXTSB = 4'h8;
    localparam logic [3:0] SUB_EXTUB = 4'h9;
    localparam logic [3:0] SUB_EXTSH = 4'hA;
    localparam logic [3:0] SUB_EXTUH = 4'hB;

endpackage

// File: rtl/misc_decode.sv
// Module: misc_decode
// Maps opcode and sub-code to an operation kind. Purely combinational.
// Assumes the caller qualifies the result with its own valid signal.
module misc_decode
    import misc_exec_pkg::*;
(
    input  logic [7:0] opcode_i,
    input  logic [3:0] subop_i,
    output op_kind_e   kind_o
);

    // Select the operation kind; every unlisted encoding is illegal.
    always_comb begin
        kind_o = K_ILLEGAL;
        unique case (opcode_i)
            OPC_GRP_E:  if (subop_i == SUB_NOP) kind_o = K_NOP;
            OPC_ANDCCR: kind_o = K_ANDCCR;
            OPC_ORCCR:  kind_o = K_ORCCR;
            OPC_STILM:  kind_o = K_STILM;
            OPC_ADDSP:  kind_o = K_ADDSP;
            OPC_EXT: begin
                unique case (subop_i)
                    SUB_EXTSB: kind_o = K_EXTSB;
                    SUB_EXTUB: kind_o = K_EXTUB;
                    SUB_EXTSH: kind_o = K_EXTSH;
                    SUB_EXTUH: kind_o = K_EXTUH;
                    default:   kind_o = K_ILLEGAL;
                endcase
            end
            default: kind_o = K_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/misc_extend.sv
// Module: misc_extend
// Widens the low byte or low halfword of a register to XLEN bits,
// either sign- or zero-filled. Purely combinational.
// Assumes NARROW_A < NARROW_B < XLEN.
module misc_extend
    import misc_exec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NARROW_A = 8,
    parameter int NARROW_B = 16
) (
    input  op_kind_e          kind_i,
    input  logic [XLEN-1:0]   data_i,
    output logic [XLEN-1:0]   data_o
);

    localparam int NUM_W = 2;

    logic [XLEN-1:0] sx [NUM_W];
    logic [XLEN-1:0] zx [NUM_W];

    // One signed and one unsigned widener per source width.
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int W = (g == 0) ? NARROW_A : NARROW_B;
        assign sx[g] = {{(XLEN-W){data_i[W-1]}}, data_i[W-1:0]};
        assign zx[g] = {{(XLEN-W){1'b0}}, data_i[W-1:0]};
    end

    // Pick the widened value requested by the operation kind.
    always_comb begin
        unique case (kind_i)
            K_EXTSB: data_o = sx[0];
            K_EXTUB: data_o = zx[0];
            K_EXTSH: data_o = sx[1];
            K_EXTUH: data_o = zx[1];
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/misc_sp_adjust.sv
// Module: misc_sp_adjust
// Adds a signed immediate, scaled by 2**SHIFT, to the stack pointer.
// Purely combinational; the sum wraps modulo 2**XLEN.
// Assumes IMM_W + SHIFT <= XLEN.
module misc_sp_adjust #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  sp_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  sp_o
);

    logic [XLEN-1:0] offset;

    // Sign-extend the immediate, scale it, then add it to the pointer.
    always_comb begin
        offset = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i} << SHIFT;
        sp_o   = sp_i + offset;
    end

endmodule

// File: rtl/misc_exec.sv
// Module: misc_exec (top)
// Executes the miscellaneous single-cycle control group. It holds the
// condition-code register and the interrupt level mask, and registers
// the write-back, the stack-pointer write and the illegal flag.
// Assumes the register file applies the writes itself, and that inputs
// are held stable around the rising clock edge.
module misc_exec
    import misc_exec_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 8,
    parameter int CCR_W   = 8,
    parameter int ILM_W   = 5,
    parameter int IDX_W   = 4,
    parameter int SP_SHFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [7:0]       opcode_i,
    input  logic [3:0]       subop_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [IDX_W-1:0] ri_idx_i,
    input  logic [XLEN-1:0]  ri_i,
    input  logic [XLEN-1:0]  sp_i,
    output logic             wb_en_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o,
    output logic             sp_we_o,
    output logic [XLEN-1:0]  sp_data_o,
    output logic [CCR_W-1:0] ccr_o,
    output logic [ILM_W-1:0] ilm_o,
    output logic             illegal_o
);

    localparam int CCR_IMM_W = (CCR_W < IMM_W) ? CCR_W : IMM_W;

    op_kind_e         kind;
    logic [XLEN-1:0]  ext_data;
    logic [XLEN-1:0]  sp_next;
    logic [CCR_W-1:0] imm_ccr;

    misc_decode u_decode (
        .opcode_i (opcode_i),
        .subop_i  (subop_i),
        .kind_o   (kind)
    );

    misc_extend #(
        .XLEN     (XLEN),
        .NARROW_A (8),
        .NARROW_B (16)
    ) u_extend (
        .kind_i (kind),
        .data_i (ri_i),
        .data_o (ext_data)
    );

    misc_sp_adjust #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .SHIFT (SP_SHFT)
    ) u_sp (
        .sp_i  (sp_i),
        .imm_i (imm_i),
        .sp_o  (sp_next)
    );

    // Fit the immediate to the CCR width for the logic operations.
    always_comb begin
        imm_ccr = '0;
        imm_ccr[CCR_IMM_W-1:0] = imm_i[CCR_IMM_W-1:0];
    end

    // Architectural state (CCR, mask) and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_o     <= '0;
            ilm_o     <= '0;
            wb_en_o   <= 1'b0;
            wb_idx_o  <= '0;
            wb_data_o <= '0;
            sp_we_o   <= 1'b0;
            sp_data_o <= '0;
            illegal_o <= 1'b0;
        end else begin
            wb_en_o   <= 1'b0;
            sp_we_o   <= 1'b0;
            illegal_o <= 1'b0;
            if (valid_i) begin
                unique case (kind)
                    K_NOP:    ;
                    K_ANDCCR: ccr_o <= ccr_o & imm_ccr;
                    K_ORCCR:  ccr_o <= ccr_o | imm_ccr;
                    K_STILM:  ilm_o <= imm_i[ILM_W-1:0];
                    K_ADDSP: begin
                        sp_we_o   <= 1'b1;
                        sp_data_o <= sp_next;
                    end
                    K_EXTSB, K_EXTUB, K_EXTSH, K_EXTUH: begin
                        wb_en_o   <= 1'b1;
                        wb_idx_o  <= ri_idx_i;
                        wb_data_o <= ext_data;
                    end
                    default: illegal_o <= 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/misc_exec_chk.sv
// Module: misc_exec_chk
// Port-level properties of misc_exec, attached through bind.
// Assumes the same clock and synchronous active-low reset as the block.
module misc_exec_chk
    import misc_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CCR_W = 8,
    parameter int ILM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [7:0]       opcode_i,
    input logic             wb_en_o,
    input logic             sp_we_o,
    input logic [CCR_W-1:0] ccr_o,
    input logic [ILM_W-1:0] ilm_o,
    input logic             illegal_o
);

    // R9
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb_en_o && !sp_we_o));

    // R8
    ccr_only_by_logic_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && (opcode_i == OPC_ANDCCR || opcode_i == OPC_ORCCR)) |=> $stable(ccr_o));

    // R5
    ilm_only_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && opcode_i == OPC_STILM) |=> $stable(ilm_o));

    // R6
    sp_write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && opcode_i == OPC_ADDSP) |=> !sp_we_o);

    // R7
    wb_write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && opcode_i == OPC_EXT) |=> !wb_en_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!wb_en_o && !sp_we_o && !illegal_o));

    // R11
    single_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en_o, sp_we_o, illegal_o}));

endmodule

bind misc_exec misc_exec_chk #(
    .XLEN  (XLEN),
    .CCR_W (CCR_W),
    .ILM_W (ILM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .opcode_i  (opcode_i),
    .wb_en_o   (wb_en_o),
    .sp_we_o   (sp_we_o),
    .ccr_o     (ccr_o),
    .ilm_o     (ilm_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_misc_exec.sv
// Bench for misc_exec: a behavioural reference model advanced on each
// rising edge, compared with every output 5 ns after each rising edge.
module tb_misc_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [3:0]  subop_i = '0;
    logic [7:0]  imm_i = '0;
    logic [3:0]  ri_idx_i = '0;
    logic [31:0] ri_i = '0;
    logic [31:0] sp_i = '0;
    logic        wb_en_o;
    logic [3:0]  wb_idx_o;
    logic [31:0] wb_data_o;
    logic        sp_we_o;
    logic [31:0] sp_data_o;
    logic [7:0]  ccr_o;
    logic [4:0]  ilm_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [7:0]  m_ccr;
    logic [4:0]  m_ilm;
    logic        m_wb, m_sp, m_ill;
    logic [3:0]  m_idx;
    logic [31:0] m_wbd, m_spd;
    string       m_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    misc_exec dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .subop_i(subop_i), .imm_i(imm_i), .ri_idx_i(ri_idx_i), .ri_i(ri_i),
        .sp_i(sp_i), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
        .wb_data_o(wb_data_o), .sp_we_o(sp_we_o), .sp_data_o(sp_data_o),
        .ccr_o(ccr_o), .ilm_o(ilm_o), .illegal_o(illegal_o)
    );

    // Reference model: what each instruction should produce next cycle.
    always @(posedge clk) begin
        m_wb  <= 1'b0;
        m_sp  <= 1'b0;
        m_ill <= 1'b0;
        if (!rst_n) begin
            m_ccr <= 8'h00; m_ilm <= 5'd0; m_tag <= "R1";
        end else if (!valid_i) begin
            m_tag <= "R10";
        end else if (opcode_i == 8'h9F && subop_i == 4'hA) begin
            m_tag <= "R2";
        end else if (opcode_i == 8'h83) begin
            m_ccr <= m_ccr & imm_i; m_tag <= "R3";
        end else if (opcode_i == 8'h93) begin
            m_ccr <= m_ccr | imm_i; m_tag <= "R4";
        end else if (opcode_i == 8'h87) begin
            m_ilm <= 5'(imm_i % 32); m_tag <= "R5";
        end else if (opcode_i == 8'hA3) begin
            m_sp  <= 1'b1;
            m_spd <= sp_i + 32'(int'($signed(imm_i)) * 4);
            m_tag <= "R6";
        end else if (opcode_i == 8'h97 && subop_i >= 4'h8 && subop_i <= 4'hB) begin
            m_wb  <= 1'b1;
            m_idx <= ri_idx_i;
            case (subop_i)
                4'h8:    m_wbd <= 32'(int'($signed(ri_i[7:0])));
                4'h9:    m_wbd <= ri_i % 256;
                4'hA:    m_wbd <= 32'(int'($signed(ri_i[15:0])));
                default: m_wbd <= ri_i % 65536;
            endcase
            m_tag <= "R7";
        end else begin
            m_ill <= 1'b1; m_tag <= "R9";
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (!done) begin
            string ccr_tag;
            string pulse_tag;
            ccr_tag   = (m_tag == "R3" || m_tag == "R4" || m_tag == "R1") ? m_tag : "R8";
            pulse_tag = (m_tag == "R9" || m_tag == "R10" || m_tag == "R1") ? m_tag : "R11";
            check(ccr_tag, "ccr", 32'(ccr_o), 32'(m_ccr));
            check(m_tag == "R5" ? "R5" : m_tag, "ilm", 32'(ilm_o), 32'(m_ilm));
            check(pulse_tag, "wb_en", 32'(wb_en_o), 32'(m_wb));
            check(pulse_tag, "sp_we", 32'(sp_we_o), 32'(m_sp));
            check(pulse_tag, "illegal", 32'(illegal_o), 32'(m_ill));
            if (m_wb) begin
                check("R7", "wb_idx", 32'(wb_idx_o), 32'(m_idx));
                check("R7", "wb_data", wb_data_o, m_wbd);
            end
            if (m_sp) check("R6", "sp_data", sp_data_o, m_spd);
        end
    end

    task automatic issue(input logic [7:0] op, input logic [3:0] sub,
                         input logic [7:0] imm, input logic [31:0] ri,
                         input logic [31:0] sp);
        @(negedge clk);
        valid_i = 1'b1; opcode_i = op; subop_i = sub; imm_i = imm;
        ri_i = ri; sp_i = sp; ri_idx_i = ri[3:0] ^ 4'h5;
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0; opcode_i = $urandom; subop_i = $urandom; imm_i = $urandom;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1; checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [6];
        ops[0] = 8'h9F; ops[1] = 8'h83; ops[2] = 8'h93;
        ops[3] = 8'h87; ops[4] = 8'hA3; ops[5] = 8'h97;
        repeat (3) @(negedge clk);          // R1 reset values checked each cycle
        rst_n = 1'b1;
        idle();                              // R1 first cycle after reset
        issue(8'h93, 4'h0, 8'h0F, 0, 0);     // R4
        issue(8'h83, 4'h0, 8'h05, 0, 0);     // R3
        issue(8'h93, 4'h0, 8'hF0, 0, 0);     // R4
        issue(8'h83, 4'h0, 8'h00, 0, 0);     // R3 clear all
        issue(8'h87, 4'h0, 8'hFF, 0, 0);     // R5 -> 0x1F
        issue(8'h87, 4'h0, 8'h23, 0, 0);     // R5 upper bits ignored -> 0x03
        issue(8'hA3, 4'h0, 8'h01, 0, 32'h1000);      // R6 +4
        issue(8'hA3, 4'h0, 8'hFF, 0, 32'h1000);      // R6 -4
        issue(8'hA3, 4'h0, 8'h80, 0, 32'h1000);      // R6 -512
        issue(8'hA3, 4'h0, 8'h7F, 0, 32'h1000);      // R6 +508
        issue(8'hA3, 4'h0, 8'hFF, 0, 32'h0);         // R6 wrap
        issue(8'h97, 4'h8, 0, 32'h1234_5680, 0);     // R7 sign byte
        issue(8'h97, 4'h9, 0, 32'hFFFF_FF80, 0);     // R7 zero byte
        issue(8'h97, 4'hA, 0, 32'h0000_8001, 0);     // R7 sign half
        issue(8'h97, 4'hB, 0, 32'hFFFF_8001, 0);     // R7 zero half
        issue(8'h97, 4'h8, 0, 32'hFFFF_FF7F, 0);     // R7 positive byte
        issue(8'h9F, 4'hA, 8'hFF, 32'hFFFF_FFFF, 0); // R2
        issue(8'h9F, 4'h9, 8'hFF, 0, 0);             // R9
        issue(8'h97, 4'h7, 8'hFF, 0, 0);             // R9
        issue(8'h97, 4'hC, 8'hFF, 0, 0);             // R9
        issue(8'h00, 4'h0, 8'hFF, 0, 0);             // R9
        idle(); idle();                              // R10
        for (int i = 0; i < 2000; i++) begin         // mixed stream, R8/R11
            int sel;
            sel = $urandom_range(0, 7);
            if (sel == 6) idle();
            else if (sel == 7) issue(8'($urandom), 4'($urandom), 8'($urandom), $urandom, $urandom);
            else issue(ops[sel], 4'($urandom_range(7, 12)), 8'($urandom), $urandom, $urandom);
        end
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule